// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh Sequencer

This block keeps a 1-Mbit pseudo-static RAM alive by driving the memory's active-low refresh strobe. After reset it waits out the power-up settling time. It then fires a short run of dummy refresh pulses and raises `ready`. From then on it issues one auto-refresh pulse per interval, so that the full 512-row array is covered inside each 8 ms period.

The block does not own the chip-enable line. Before each strobe it raises `ownReq` to the access arbiter. It waits until the arbiter answers with `grant` and no access cycle is running. It then lets chip enable sit high for its minimum time before the strobe may fall.

A host can park the memory in self-refresh by raising `sleepReq`. The strobe is held low past the self-refresh entry time and `sleepAck` is raised. On `wakeReq` the strobe is released and chip enable stays blocked for the exit delay. A catch-up burst of refresh pulses then runs back to back, and `wakeAck` is pulsed once the burst is done.

Every timing minimum is a parameter in nanoseconds. Each is rounded up to whole clock cycles.

Top module: `psram_refresh_seq`

## Requirements
- R1: While `rstN` is low and for PWRUP cycles after its release, `refreshN` is 1 and `ownReq`, `ready`, `sleepAck`, `wakeAck` and `timingErr` are 0. PWRUP is the power-up time divided by the clock period, rounded up. `ownReq` rises in the PWRUP-th cycle after release.
- R2: After the power-up wait, exactly DUMMY_CYCLES refresh pulses are issued and then `ready` goes to 1. `ready` stays 1 until the next reset.
- R3: Every auto-refresh low phase of `refreshN` lasts exactly LOW cycles. LOW never exceeds the strobe's maximum low time.
- R4: Within a burst, consecutive falling edges of `refreshN` are max(LOW+HIGH, CYCLE) cycles apart. HIGH is the minimum high time and CYCLE is the minimum refresh cycle time, both in cycles.
- R5: `ownReq` rises before any strobe and stays 1 until the strobe's high phase has ended. `refreshN` falls GAP+1 cycles after the first cycle that sees `grant`=1 and `accessBusy`=0, where GAP is the chip-enable-high minimum in cycles.
- R6: While ready and not asleep, one refresh becomes due every INTERVAL cycles, so `ownReq` rises at exactly that spacing. After a wake-up the interval count restarts, and `ownReq` rises INTERVAL+1 cycles after `wakeAck`.
- R7: If a refresh falls due while the previous one is still unserved, `timingErr` becomes 1 and stays 1 until reset.
- R8: A `sleepReq` is not taken while `accessBusy` is 1: `ownReq` stays 0 during that time.
- R9: In sleep, `refreshN` is held low for SELF cycles before `sleepAck` rises. It stays low with `ownReq`=1 until `wakeReq`, and no refresh falls due while asleep.
- R10: On `wakeReq`, `refreshN` rises in the next cycle. `ownReq` stays 1 and no strobe falls for EXIT cycles, so the first catch-up strobe is seen EXIT+1 cycles after `wakeReq`.
- R11: The catch-up burst is exactly BURST_COUNT pulses. It is followed by a single-cycle `wakeAck`, with `ownReq` already 0 in the cycle after.
- R12: Each nanosecond minimum N becomes ceil(N/period) cycles. For example, a 25 ns low time at a 10 ns clock gives 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accessBusy | input | 1 | An access cycle holds chip enable |
| grant | input | 1 | Arbiter hands chip enable to this block |
| sleepReq | input | 1 | Host asks for self-refresh |
| wakeReq | input | 1 | Host asks to leave self-refresh |
| refreshN | output | 1 | Active-low refresh strobe to the memory |
| ownReq | output | 1 | Request to hold chip enable high |
| ready | output | 1 | Power-up sequence complete |
| sleepAck | output | 1 | Memory is in self-refresh |
| wakeAck | output | 1 | One-cycle pulse after the catch-up burst |
| timingErr | output | 1 | Sticky refresh-interval overrun flag |

## Verification
Periodic refreshes are run against a table of arbiter grant latencies and busy tails. This sets apart a strobe held back by a late grant from one held back by a running access, and shows that only the later of the two sets the delay. The power-up dummy run, the catch-up burst and the single periodic pulse are each measured for pulse count, low width and pulse spacing, so a wrong burst length or spacing shows in any of the three. Sleep is tried first with an access in progress, then idle. A wake-up is timed against both the exit hold-off and the restart of the interval count. A withheld grant across a full interval drives the overrun flag, and a second reset clears it.

// File: rtl/psram_refresh_pkg.sv
package psram_refresh_pkg;

  typedef enum logic [2:0] {
    TS_GAP,
    TS_LOW,
    TS_HIGH,
    TS_EXIT,
    TS_SELF
  } timerSel_e;

  typedef enum logic [1:0] {
    BS_ONE,
    BS_DUMMY,
    BS_FULL
  } burstSel_e;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_REQ,
    ST_GAP,
    ST_LOW,
    ST_HIGH,
    ST_SELF,
    ST_HOLD,
    ST_EXIT
  } state_e;

  typedef enum logic [1:0] {
    PU_INIT,
    PU_PERIODIC,
    PU_SLEEP,
    PU_CATCHUP
  } purpose_e;

  typedef struct packed {
    logic      loadTimer;
    timerSel_e timerSel;
    logic      loadBurst;
    burstSel_e burstSel;
    logic      decBurst;
    logic      clrPending;
    logic      runInterval;
    logic      restartInterval;
  } ctrlStrobe_t;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_refresh_dp.sv
module psram_refresh_dp
  import psram_refresh_pkg::*;
#(
  parameter int PWRUP_CYC    = 10000,
  parameter int GAP_CYC      = 4,
  parameter int LOW_CYC      = 3,
  parameter int HIGH_CYC     = 9,
  parameter int EXIT_CYC     = 15,
  parameter int SELF_CYC     = 800000,
  parameter int INTERVAL_CYC = 1560,
  parameter int DUMMY_CNT    = 9,
  parameter int BURST_CNT    = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic        timerDone,
  output logic        burstLast,
  output logic        pending,
  output logic        timingErr
);

  localparam int MAX_T  = maxOf(maxOf(maxOf(PWRUP_CYC, SELF_CYC), maxOf(GAP_CYC, EXIT_CYC)),
                                maxOf(LOW_CYC, HIGH_CYC));
  localparam int TMR_W  = $clog2(MAX_T + 1);
  localparam int BC_W   = $clog2(maxOf(DUMMY_CNT, BURST_CNT) + 1);
  localparam int IV_W   = $clog2(INTERVAL_CYC + 1);

  localparam logic [TMR_W-1:0] LD_PWRUP = TMR_W'(PWRUP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_GAP   = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_LOW   = TMR_W'(LOW_CYC - 1);
  localparam logic [TMR_W-1:0] LD_HIGH  = TMR_W'(HIGH_CYC - 1);
  localparam logic [TMR_W-1:0] LD_EXIT  = TMR_W'(EXIT_CYC - 1);
  localparam logic [TMR_W-1:0] LD_SELF  = TMR_W'(SELF_CYC - 1);
  localparam logic [IV_W-1:0]  IV_LAST  = IV_W'(INTERVAL_CYC - 1);

  // phase timer shared by every timed state
  logic [TMR_W-1:0] timerQ;
  logic [TMR_W-1:0] loadVal;

  always_comb begin
    case (strobe.timerSel)
      TS_GAP:  loadVal = LD_GAP;
      TS_LOW:  loadVal = LD_LOW;
      TS_HIGH: loadVal = LD_HIGH;
      TS_EXIT: loadVal = LD_EXIT;
      default: loadVal = LD_SELF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 timerQ <= LD_PWRUP;
    else if (strobe.loadTimer) timerQ <= loadVal;
    else if (timerQ != '0)     timerQ <= timerQ - 1'b1;
  end

  assign timerDone = (timerQ == '0);

  // pulses remaining in the current burst
  logic [BC_W-1:0] burstQ;
  logic [BC_W-1:0] burstVal;

  always_comb begin
    case (strobe.burstSel)
      BS_DUMMY: burstVal = BC_W'(DUMMY_CNT);
      BS_FULL:  burstVal = BC_W'(BURST_CNT);
      default:  burstVal = BC_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 burstQ <= '0;
    else if (strobe.loadBurst) burstQ <= burstVal;
    else if (strobe.decBurst)  burstQ <= burstQ - 1'b1;
  end

  assign burstLast = (burstQ == BC_W'(1));

  // refresh-interval tracker
  logic [IV_W-1:0] ivQ;
  logic            pendQ;
  logic            errQ;
  logic            tick;

  assign tick = strobe.runInterval && (ivQ == IV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivQ   <= '0;
      pendQ <= 1'b0;
    end else if (strobe.restartInterval) begin
      ivQ   <= '0;
      pendQ <= 1'b0;
    end else begin
      if (strobe.runInterval) ivQ <= tick ? '0 : ivQ + 1'b1;
      pendQ <= (pendQ && !strobe.clrPending) || tick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else if (tick && pendQ && !strobe.clrPending) errQ <= 1'b1;
  end

  assign pending   = pendQ;
  assign timingErr = errQ;

  // R11: control never counts a burst below its final pulse
  p_no_dec_last_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decBurst |-> !burstLast);

  // R7: overrun flag never clears without reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    timingErr |=> timingErr);

endmodule

// File: rtl/psram_refresh_ctrl.sv
module psram_refresh_ctrl
  import psram_refresh_pkg::*;
#(
  parameter int LOW_MAX_CYC = 800
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accessBusy,
  input  logic        grant,
  input  logic        sleepReq,
  input  logic        wakeReq,
  input  logic        timerDone,
  input  logic        burstLast,
  input  logic        pending,
  output ctrlStrobe_t strobe,
  output logic        refreshN,
  output logic        ownReq,
  output logic        ready,
  output logic        sleepAck,
  output logic        wakeAck
);

  state_e   stateQ, stateD;
  purpose_e purposeQ, purposeD;
  logic     readyQ, inSleepQ, wakeAckQ;
  logic     burstEnd;

  always_comb begin
    stateD   = stateQ;
    purposeD = purposeQ;
    strobe   = '0;
    burstEnd = 1'b0;
    strobe.runInterval = readyQ && !inSleepQ;
    case (stateQ)
      ST_PWRUP: if (timerDone) begin
        stateD          = ST_REQ;
        purposeD        = PU_INIT;
        strobe.loadBurst = 1'b1;
        strobe.burstSel  = BS_DUMMY;
      end
      ST_IDLE: if (pending) begin
        stateD          = ST_REQ;
        purposeD        = PU_PERIODIC;
        strobe.loadBurst = 1'b1;
        strobe.burstSel  = BS_ONE;
      end else if (sleepReq && !accessBusy) begin
        stateD   = ST_REQ;
        purposeD = PU_SLEEP;
      end
      ST_REQ: if (grant && !accessBusy) begin
        stateD          = ST_GAP;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TS_GAP;
      end
      ST_GAP: if (timerDone) begin
        strobe.loadTimer = 1'b1;
        if (purposeQ == PU_SLEEP) begin
          stateD          = ST_SELF;
          strobe.timerSel = TS_SELF;
        end else begin
          stateD            = ST_LOW;
          strobe.timerSel   = TS_LOW;
          strobe.clrPending = (purposeQ == PU_PERIODIC);
        end
      end
      ST_LOW: if (timerDone) begin
        stateD          = ST_HIGH;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TS_HIGH;
      end
      ST_HIGH: if (timerDone) begin
        if (burstLast) begin
          stateD   = ST_IDLE;
          burstEnd = 1'b1;
          strobe.restartInterval = (purposeQ == PU_CATCHUP);
        end else begin
          stateD          = ST_LOW;
          strobe.decBurst  = 1'b1;
          strobe.loadTimer = 1'b1;
          strobe.timerSel  = TS_LOW;
        end
      end
      ST_SELF: if (timerDone) stateD = ST_HOLD;
      ST_HOLD: if (wakeReq) begin
        stateD          = ST_EXIT;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TS_EXIT;
      end
      ST_EXIT: if (timerDone) begin
        stateD          = ST_LOW;
        purposeD        = PU_CATCHUP;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TS_LOW;
        strobe.loadBurst = 1'b1;
        strobe.burstSel  = BS_FULL;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_PWRUP;
      purposeQ <= PU_INIT;
      readyQ   <= 1'b0;
      inSleepQ <= 1'b0;
      wakeAckQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      purposeQ <= purposeD;
      wakeAckQ <= burstEnd && (purposeQ == PU_CATCHUP);
      if (burstEnd && purposeQ == PU_INIT) readyQ <= 1'b1;
      if (stateQ == ST_IDLE && purposeD == PU_SLEEP && stateD == ST_REQ) inSleepQ <= 1'b1;
      else if (burstEnd && purposeQ == PU_CATCHUP) inSleepQ <= 1'b0;
    end
  end

  assign refreshN = !(stateQ inside {ST_LOW, ST_SELF, ST_HOLD});
  assign ownReq   = !(stateQ inside {ST_PWRUP, ST_IDLE});
  assign ready    = readyQ;
  assign sleepAck = (stateQ == ST_HOLD);
  assign wakeAck  = wakeAckQ;

  // run length of the auto-refresh low phase, for the upper-bound check
  localparam int LR_W = $clog2(LOW_MAX_CYC + 2);
  logic [LR_W-1:0] lowRunQ;

  always_ff @(posedge clk) begin
    if (!rstN) lowRunQ <= '0;
    else if (stateQ != ST_LOW) lowRunQ <= '0;
    else if (lowRunQ != {LR_W{1'b1}}) lowRunQ <= lowRunQ + 1'b1;
  end

  p_low_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    32'(lowRunQ) <= LOW_MAX_CYC);

  p_fall_owned_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refreshN) |-> ownReq && grant);

  p_sleepack_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    sleepAck |-> !refreshN && ownReq);

  p_exit_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshN) && $past(sleepAck) |-> ownReq);

  p_ready_stays_r2: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  p_wake_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    wakeAck |=> !wakeAck && !ownReq);

endmodule

// File: rtl/psram_refresh_seq.sv
module psram_refresh_seq
  import psram_refresh_pkg::*;
#(
  parameter int CLK_PERIOD_NS   = 10,
  parameter int PWRUP_NS        = 100000,
  parameter int DUMMY_CYCLES    = 9,
  parameter int REF_INTERVAL_NS = 15600,
  parameter int STROBE_LOW_NS   = 30,
  parameter int STROBE_LOW_MAX_NS = 8000,
  parameter int STROBE_HIGH_NS  = 30,
  parameter int REF_CYCLE_NS    = 120,
  parameter int CE_HIGH_NS      = 40,
  parameter int SELF_LOW_NS     = 8000000,
  parameter int SELF_EXIT_NS    = 150,
  parameter int BURST_COUNT     = 512
) (
  input  logic clk,
  input  logic rstN,
  input  logic accessBusy,
  input  logic grant,
  input  logic sleepReq,
  input  logic wakeReq,
  output logic refreshN,
  output logic ownReq,
  output logic ready,
  output logic sleepAck,
  output logic wakeAck,
  output logic timingErr
);

  // R12: every minimum rounded up to whole cycles
  localparam int PWRUP_CYC    = ns2cyc(PWRUP_NS, CLK_PERIOD_NS);
  localparam int GAP_CYC      = ns2cyc(CE_HIGH_NS, CLK_PERIOD_NS);
  localparam int LOW_CYC      = ns2cyc(STROBE_LOW_NS, CLK_PERIOD_NS);
  localparam int RCYC_CYC     = ns2cyc(REF_CYCLE_NS, CLK_PERIOD_NS);
  localparam int HIGH_MIN_CYC = ns2cyc(STROBE_HIGH_NS, CLK_PERIOD_NS);
  localparam int HIGH_CYC     = maxOf(HIGH_MIN_CYC, (RCYC_CYC > LOW_CYC) ? RCYC_CYC - LOW_CYC : 1);
  localparam int EXIT_CYC     = ns2cyc(SELF_EXIT_NS, CLK_PERIOD_NS);
  localparam int SELF_CYC     = ns2cyc(SELF_LOW_NS, CLK_PERIOD_NS);
  localparam int INTERVAL_CYC = REF_INTERVAL_NS / CLK_PERIOD_NS;
  localparam int LOW_MAX_CYC  = STROBE_LOW_MAX_NS / CLK_PERIOD_NS;

  ctrlStrobe_t strobe;
  logic timerDone, burstLast, pending;

  psram_refresh_ctrl #(
    .LOW_MAX_CYC(LOW_MAX_CYC)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .accessBusy(accessBusy),
    .grant     (grant),
    .sleepReq  (sleepReq),
    .wakeReq   (wakeReq),
    .timerDone (timerDone),
    .burstLast (burstLast),
    .pending   (pending),
    .strobe    (strobe),
    .refreshN  (refreshN),
    .ownReq    (ownReq),
    .ready     (ready),
    .sleepAck  (sleepAck),
    .wakeAck   (wakeAck)
  );

  psram_refresh_dp #(
    .PWRUP_CYC   (PWRUP_CYC),
    .GAP_CYC     (GAP_CYC),
    .LOW_CYC     (LOW_CYC),
    .HIGH_CYC    (HIGH_CYC),
    .EXIT_CYC    (EXIT_CYC),
    .SELF_CYC    (SELF_CYC),
    .INTERVAL_CYC(INTERVAL_CYC),
    .DUMMY_CNT   (DUMMY_CYCLES),
    .BURST_CNT   (BURST_COUNT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .timerDone(timerDone),
    .burstLast(burstLast),
    .pending  (pending),
    .timingErr(timingErr)
  );

endmodule

// File: tb/psram_refresh_seq_tb.sv
module psram_refresh_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  // expected cycle counts derived from the bench parameter overrides
  localparam int X_PWRUP    = 20;
  localparam int X_GAP      = 4;
  localparam int X_LOW      = 3;
  localparam int X_SPACING  = 12;
  localparam int X_EXIT     = 15;
  localparam int X_SELF     = 50;
  localparam int X_INTERVAL = 100;
  localparam int X_DUMMY    = 9;
  localparam int X_BURST    = 8;

  // grant latency, busy tail, expected ownReq-to-strobe delay
  localparam int ROWS = 5;
  localparam int TBL [ROWS][3] = '{
    '{0, 0, 5},
    '{3, 0, 8},
    '{0, 6, 11},
    '{4, 9, 14},
    '{7, 2, 12}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accessBusy = 1'b0;
  logic manualGrant = 1'b0;
  logic autoGrant = 1'b1;
  logic sleepReq = 1'b0;
  logic wakeReq = 1'b0;
  logic grant;
  logic refreshN, ownReq, ready, sleepAck, wakeAck, timingErr;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  assign grant = autoGrant ? ownReq : manualGrant;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psram_refresh_seq #(
    .PWRUP_NS       (200),
    .DUMMY_CYCLES   (9),
    .REF_INTERVAL_NS(1000),
    .STROBE_LOW_NS  (25),
    .SELF_LOW_NS    (500),
    .BURST_COUNT    (8)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .accessBusy(accessBusy),
    .grant     (grant),
    .sleepReq  (sleepReq),
    .wakeReq   (wakeReq),
    .refreshN  (refreshN),
    .ownReq    (ownReq),
    .ready     (ready),
    .sleepAck  (sleepAck),
    .wakeAck   (wakeAck),
    .timingErr (timingErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // follows a burst, checking low widths and fall spacing, until stop flag
  task automatic runBurst(input bit stopOnWake, input bit inLow, output int pulses);
    int lastFall;
    int lowW;
    logic prev;
    pulses   = inLow ? 1 : 0;
    lastFall = cyc;
    lowW     = inLow ? 1 : 0;
    prev     = refreshN;
    forever begin
      @(negedge clk);
      if (!refreshN) begin
        if (prev) begin
          pulses++;
          if (pulses > 1) chk(cyc - lastFall == X_SPACING, "R4 fall spacing", cyc - lastFall, X_SPACING);
          lastFall = cyc;
          lowW = 1;
        end else lowW++;
      end else if (!prev) begin
        chk(lowW == X_LOW, "R3/R12 low width", lowW, X_LOW);
      end
      prev = refreshN;
      if (stopOnWake ? wakeAck : ready) break;
    end
  endtask

  int n;
  int p;
  int viol;
  int prevRise;

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(refreshN && !ownReq && !ready && !sleepAck && !wakeAck && !timingErr, "R1 reset outputs",
        {refreshN, ownReq, ready, sleepAck, wakeAck, timingErr}, 6'b100000);
    rstN = 1'b1;

    // R1: power-up wait length
    n = 0;
    viol = 0;
    while (!ownReq) begin
      @(negedge clk);
      n++;
      if (!refreshN || ready) viol++;
    end
    chk(n == X_PWRUP, "R1 power-up wait", n, X_PWRUP);
    chk(viol == 0, "R1 quiet during wait", viol, 0);

    // R2: dummy pulses then ready
    runBurst(1'b0, 1'b0, p);
    chk(p == X_DUMMY, "R2 dummy pulse count", p, X_DUMMY);
    @(negedge clk);
    chk(ready == 1'b1, "R2 ready holds", ready, 1);

    // R5/R6: periodic refresh against the grant/busy table
    autoGrant = 1'b0;
    prevRise = -1;
    for (int r = 0; r < ROWS; r++) begin
      accessBusy = (TBL[r][1] > 0);
      while (!ownReq) @(negedge clk);
      if (prevRise >= 0) chk(cyc - prevRise == X_INTERVAL, "R6 refresh spacing", cyc - prevRise, X_INTERVAL);
      prevRise = cyc;
      n = 0;
      forever begin
        if (n >= TBL[r][0]) manualGrant = 1'b1;
        if (n >= TBL[r][1]) accessBusy = 1'b0;
        if (!refreshN) break;
        @(negedge clk);
        n++;
      end
      chk(n == TBL[r][2], "R5 strobe delay after grant", n, TBL[r][2]);
      p = 0;
      while (!refreshN) begin @(negedge clk); p++; end
      chk(p == X_LOW, "R3 periodic low width", p, X_LOW);
      while (ownReq) begin @(negedge clk); p++; end
      chk(p == X_SPACING, "R5 ownership held through strobe", p, X_SPACING);
      manualGrant = 1'b0;
    end

    // R8: sleep request blocked while an access runs
    autoGrant = 1'b1;
    accessBusy = 1'b1;
    sleepReq = 1'b1;
    viol = 0;
    repeat (10) begin @(negedge clk); if (ownReq) viol++; end
    chk(viol == 0, "R8 sleep waits for idle bus", viol, 0);
    accessBusy = 1'b0;

    // R9: self-refresh entry time
    while (refreshN) @(negedge clk);
    n = 0;
    while (!sleepAck) begin @(negedge clk); n++; end
    chk(n == X_SELF, "R9 self-refresh entry time", n, X_SELF);
    viol = 0;
    repeat (300) begin
      @(negedge clk);
      if (refreshN || !ownReq || timingErr || !sleepAck) viol++;
    end
    chk(viol == 0, "R9 strobe held low while asleep", viol, 0);

    // R10: exit hold-off
    sleepReq = 1'b0;
    wakeReq = 1'b1;
    n = 0;
    viol = 0;
    begin
      bit sawHigh;
      sawHigh = 1'b0;
      do begin
        @(negedge clk);
        n++;
        if (refreshN) sawHigh = 1'b1;
        if (!ownReq) viol++;
      end while (!(sawHigh && !refreshN));
    end
    chk(n == X_EXIT + 1, "R10 first catch-up strobe delay", n, X_EXIT + 1);
    chk(viol == 0, "R10 ownership held during exit", viol, 0);

    // R11: catch-up burst length and acknowledge
    runBurst(1'b1, 1'b1, p);
    chk(p == X_BURST, "R11 catch-up pulse count", p, X_BURST);
    wakeReq = 1'b0;
    @(negedge clk);
    chk(!wakeAck && !ownReq, "R11 single-cycle wakeAck", {wakeAck, ownReq}, 0);

    // R6: interval restarts after wake
    n = 1;
    while (!ownReq) begin @(negedge clk); n++; end
    chk(n == X_INTERVAL + 1, "R6 interval restart after wake", n, X_INTERVAL + 1);
    while (ownReq) @(negedge clk);

    // R7: withheld grant overruns the interval
    autoGrant = 1'b0;
    manualGrant = 1'b0;
    while (!ownReq) @(negedge clk);
    chk(timingErr == 1'b0, "R7 no error before overrun", timingErr, 0);
    n = 0;
    while (!timingErr) begin @(negedge clk); n++; end
    chk(n == X_INTERVAL - 1, "R7 overrun flagged", n, X_INTERVAL - 1);
    manualGrant = 1'b1;
    repeat (40) @(negedge clk);
    chk(timingErr == 1'b1, "R7 error sticky", timingErr, 1);

    // R1: second reset clears everything
    rstN = 1'b0;
    autoGrant = 1'b1;
    repeat (2) @(negedge clk);
    chk(!timingErr && !ready && refreshN && !ownReq, "R1 reset clears state",
        {timingErr, ready, refreshN, ownReq}, 4'b0010);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule